// File: doc/BRIEF.md
# Over-Current Fault Restart Controller

This block supervises a bank of regulator channels. It takes a synchronous over-current indication for each channel and drives that channel's PWM drive enable and soft-start request. When a channel trips, its drive enable drops in the same cycle and a retry timer starts. When the timer expires, the channel gets its drive back through a one-cycle soft-start request, never through an abrupt full-output return.

Each channel has a follower mask that software writes. A mask bit names another channel that is shut down and retried on the same schedule as the tripping channel. Only the tripping channel's own mask is used, so a follower's mask never spreads the shutdown further. A sticky fault flag records which channel tripped. Software reads it through a small register port and clears it by writing ones.

The retry time comes from two parameters, the clock frequency and the timeout in microseconds. The default is 200 ms at 50 MHz, and a bench can shorten it to a few cycles.

Top module: `ocp_restart_ctrl`

## Requirements
- R1: After reset every `pwm_en` bit is 1, every `soft_start_req` bit is 0, and the fault flags and all follower masks read as 0.
- R2: When `oc_in[i]` is high while channel i is not waiting out a timeout, `pwm_en[i]` is 0 in that same cycle. It stays 0 for the next T cycles, where T = CLK_HZ*TIMEOUT_US/1e6.
- R3: In the cycle after those T cycles, `soft_start_req[i]` is 1 for exactly one cycle with `pwm_en[i]` at 1, and the channel then runs normally. An over-current in that cycle counts as a new trip and suppresses the request.
- R4: An over-current on a channel that is already waiting neither restarts nor extends its timer.
- R5: Register address k+1 holds channel k's follower mask, with bit i naming channel i. A new trip on k also drops `pwm_en[i]` in the same cycle and retries channel i on the same schedule.
- R6: A follower that is already waiting when its leader trips keeps its own timer and soft-starts at its own time.
- R7: Follower masks do not chain. A channel shut down only as a follower does not apply its own mask.
- R8: Register address 0 reads the sticky fault flags. Bit i is set one cycle after a new trip that channel i itself caused. Followers get no flag.
- R9: Writing address 0 clears each flag whose data bit is 1. A new trip in the same cycle as a clear wins and leaves the flag set. Addresses above NCH read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_in | input | NCH | Synchronous over-current indication per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (0 flags, k+1 follower mask of channel k) |
| reg_wdata | input | NCH | Register write data |
| reg_rdata | output | NCH | Register read data, combinational on `reg_addr` |
| pwm_en | output | NCH | PWM drive enable per channel |
| soft_start_req | output | NCH | One-cycle soft-start request per channel |

## Verification
Assertions run on every cycle and check these properties:
- An asserted over-current never coexists with an enabled drive.
- A trip loads the full timeout.
- A waiting timer only counts down and is never reloaded.
- A soft-start request lasts one cycle and follows a wait.
- Flags only fall on a clear write and always rise after a new trip.

Some behaviour only the bench scenarios can show:
- The exact length of the off time.
- Simultaneous shutdown of followers.
- The separate timing of a follower that was already waiting.
- The absence of cascade through a second mask.
- The priority of a set over a clear in the same cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    CH_RUN     = 2'd0,
    CH_WAIT    = 2'd1,
    CH_RESTART = 2'd2
  } ch_state_e;

  // Retry length in clock cycles, never below one.
  function automatic longint timeout_cycles(longint clk_hz, longint time_us);
    longint c;
    c = (clk_hz * time_us) / 64'd1000000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/ocp_follow_map.sv
module ocp_follow_map #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]          new_fault,
  input  logic [NCH-1:0][NCH-1:0] follow_cfg,
  output logic [NCH-1:0]          trip
);

  // A channel trips on its own new fault or as a direct follower of one;
  // only the leader's mask is read, so there is no second hop.
  function automatic logic [NCH-1:0] follow_trip(
    input logic [NCH-1:0]          nf,
    input logic [NCH-1:0][NCH-1:0] cfg
  );
    logic [NCH-1:0] r;
    r = nf;
    for (int j = 0; j < NCH; j++) begin
      if (nf[j]) r = r | cfg[j];
    end
    return r;
  endfunction

  assign trip = follow_trip(new_fault, follow_cfg);

endmodule

// File: rtl/ocp_chan_fsm.sv
module ocp_chan_fsm
  import ocp_pkg::*;
#(
  parameter int          CNT_W = 24,
  parameter logic [CNT_W-1:0] LOAD = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc,
  input  logic trip,
  output logic new_fault,
  output logic pwm_en,
  output logic soft_start_req
);

  ch_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             waiting;
  logic             timer_done;

  assign waiting    = (state == CH_WAIT);
  assign timer_done = waiting && (cnt == '0);
  assign new_fault  = oc && !waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_RUN;
      cnt   <= '0;
    end else begin
      unique case (state)
        CH_WAIT: begin
          if (timer_done) state <= CH_RESTART;
          else            cnt   <= cnt - 1'b1;
        end
        default: begin
          if (trip) begin
            state <= CH_WAIT;
            cnt   <= LOAD;
          end else begin
            state <= CH_RUN;
          end
        end
      endcase
    end
  end

  assign pwm_en         = !waiting && !trip;
  assign soft_start_req = (state == CH_RESTART) && !trip;

  // R2
  trip_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !waiting) |=> (waiting && cnt == LOAD));

  // R4
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && cnt != '0) |=> (waiting && cnt == $past(cnt) - 1'b1));

  // R3
  ss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start_req |=> !soft_start_req);

  // R3
  ss_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start_req |-> $past(waiting));

endmodule

// File: rtl/ocp_regs.sv
module ocp_regs #(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [NCH-1:0]          wdata,
  input  logic [NCH-1:0]          set_flags,
  output logic [NCH-1:0][NCH-1:0] follow_cfg,
  output logic [NCH-1:0]          rdata
);

  logic [NCH-1:0] flags;
  logic           flag_sel;
  logic [NCH-1:0] clr_mask;

  assign flag_sel = (addr == '0);
  assign clr_mask = (wr && flag_sel) ? wdata : '0;

  // set after clear, so a new trip wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_flags;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)                              follow_cfg[k] <= '0;
      else if (wr && addr == AW'(k + 1))       follow_cfg[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (flag_sel) rdata = flags;
    for (int k = 0; k < NCH; k++) begin
      if (addr == AW'(k + 1)) rdata = follow_cfg[k];
    end
  end

  // R8
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(set_flags)) == $past(set_flags)));

  // R9
  flag_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && flag_sel) |=> (($past(flags) & ~flags) == '0));

endmodule

// File: rtl/ocp_restart_ctrl.sv
module ocp_restart_ctrl
  import ocp_pkg::*;
#(
  parameter int     NCH        = 4,
  parameter longint CLK_HZ     = 50000000,
  parameter longint TIMEOUT_US = 200000,
  localparam int    AW         = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_in,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] reg_rdata,
  output logic [NCH-1:0] pwm_en,
  output logic [NCH-1:0] soft_start_req
);

  localparam longint TO_CYC = timeout_cycles(CLK_HZ, TIMEOUT_US);
  localparam int     CNT_W  = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TO_CYC - 1);

  logic [NCH-1:0]          new_fault;
  logic [NCH-1:0]          trip;
  logic [NCH-1:0][NCH-1:0] follow_cfg;

  ocp_follow_map #(.NCH(NCH)) u_map (
    .new_fault  (new_fault),
    .follow_cfg (follow_cfg),
    .trip       (trip)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocp_chan_fsm #(.CNT_W(CNT_W), .LOAD(LOAD)) u_ch (
      .clk            (clk),
      .rst_n          (rst_n),
      .oc             (oc_in[i]),
      .trip           (trip[i]),
      .new_fault      (new_fault[i]),
      .pwm_en         (pwm_en[i]),
      .soft_start_req (soft_start_req[i])
    );
  end

  ocp_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .set_flags  (new_fault),
    .follow_cfg (follow_cfg),
    .rdata      (reg_rdata)
  );

  // R2
  oc_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_in & pwm_en) == '0);

  // R5
  follower_needs_leader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip & ~new_fault) != '0) |-> (new_fault != '0));

endmodule

// File: tb/ocp_restart_ctrl_bench.sv
module ocp_restart_ctrl_bench;
  localparam int  N          = 4;
  localparam int  T          = 20;
  localparam int  AW         = $clog2(N + 1);
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  oc = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  wire  [N-1:0]  pwm, ss, rdata;

  int vecs = 0, bad = 0, stepn = 0;
  int ms[N];                 // 0 run, 1 wait, 2 restart
  int mc[N];
  logic [N-1:0] mflags;
  logic [N-1:0] mcfg[N];
  logic [N-1:0] obs_pwm, obs_ss, obs_rd;

  ocp_restart_ctrl #(.NCH(N), .CLK_HZ(1000000), .TIMEOUT_US(T)) u_ocp_restart_ctrl (
    .clk(clk), .rst_n(rst_n), .oc_in(oc), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pwm_en(pwm), .soft_start_req(ss)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [N-1:0] m_newf(logic [N-1:0] o);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = o[k] && (ms[k] != 1);
    return r;
  endfunction

  function automatic logic [N-1:0] m_trip(logic [N-1:0] nf);
    logic [N-1:0] r;
    r = nf;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        if (nf[j] && mcfg[j][i]) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int k = 0; k < N; k++) begin ms[k] = 0; mc[k] = 0; mcfg[k] = '0; end
    mflags = '0;
  endtask

  // one cycle: drive at negedge, compare, advance the model, wait for next negedge
  task automatic step(logic [N-1:0] o, logic w, logic [AW-1:0] a, logic [N-1:0] d, string tag);
    logic [N-1:0] nf, tr, ep, es, er, clr;
    oc = o; wr = w; addr = a; wdata = d;
    #1;
    nf = m_newf(o);
    tr = m_trip(nf);
    for (int k = 0; k < N; k++) begin
      ep[k] = (ms[k] != 1) && !tr[k];
      es[k] = (ms[k] == 2) && !tr[k];
    end
    if (a == 0) er = mflags;
    else if (int'(a) <= N) er = mcfg[int'(a) - 1];
    else er = '0;
    chk(tag, "pwm_en", pwm, ep);
    chk(tag, "soft_start_req", ss, es);
    chk(tag, "reg_rdata", rdata, er);
    obs_pwm = pwm; obs_ss = ss; obs_rd = rdata;
    for (int k = 0; k < N; k++) begin
      if (ms[k] == 1) begin
        if (mc[k] == 0) ms[k] = 2; else mc[k] = mc[k] - 1;
      end else if (tr[k]) begin
        ms[k] = 1; mc[k] = T - 1;
      end else ms[k] = 0;
    end
    clr = (w && a == 0) ? d : '0;
    mflags = (mflags & ~clr) | nf;
    if (w && a != 0 && int'(a) <= N) mcfg[int'(a) - 1] = d;
    stepn++;
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int c = 0; c < n; c++) step('0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int lows, ssat, ss1, t0;
    void'($urandom(32'h5EED));
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and registers
    for (int a = 0; a <= N; a++) begin
      step('0, 1'b0, AW'(a), '0, "R1");
      chk("R1", "reset read", obs_rd, '0);
    end
    chk("R1", "reset pwm_en", obs_pwm, '1);

    // R2 / R3 single trip on ch0
    lows = 0; ssat = -1;
    step(4'b0001, 1'b0, '0, '0, "R2");
    if (!obs_pwm[0]) lows++;
    for (int c = 0; c < T + 3; c++) begin
      step('0, 1'b0, '0, '0, "R3");
      if (!obs_pwm[0]) lows++;
      if (obs_ss[0]) ssat = c;
    end
    chk_int("R2", "off cycles ch0", lows, T + 1);
    chk_int("R3", "soft-start cycle ch0", ssat, T);

    // R4 repeated over-current during wait
    lows = 0;
    step(4'b0010, 1'b0, '0, '0, "R4");
    if (!obs_pwm[1]) lows++;
    for (int c = 0; c < T + 3; c++) begin
      step((c == 5 || c == 12) ? 4'b0010 : 4'b0000, 1'b0, '0, '0, "R4");
      if (!obs_pwm[1]) lows++;
    end
    chk_int("R4", "off cycles ch1", lows, T + 1);

    // R5 / R8 follower shut down with leader, flag only for leader
    step('0, 1'b1, '0, '1, "R9");
    step('0, 1'b1, AW'(3), 4'b1000, "R5");
    step(4'b0100, 1'b0, '0, '0, "R5");
    chk("R5", "leader+follower off", obs_pwm, 4'b0011);
    ssat = -1;
    for (int c = 0; c < T + 3; c++) begin
      step('0, 1'b0, '0, '0, "R5");
      if (obs_ss == 4'b1100 && ssat < 0) ssat = c;
    end
    chk_int("R5", "joint soft-start", ssat, T);
    chk("R8", "flags leader only", obs_rd, 4'b0100);

    // R6 follower already waiting keeps own timer
    step('0, 1'b1, '0, '1, "R9");
    step('0, 1'b1, AW'(3), '0, "R5");
    step('0, 1'b1, AW'(1), 4'b0010, "R6");
    step(4'b0010, 1'b0, '0, '0, "R6");
    t0 = stepn; ss1 = -1;
    idle(5, "R6");
    step(4'b0001, 1'b0, '0, '0, "R6");
    for (int c = 0; c < T + 8; c++) begin
      step('0, 1'b0, '0, '0, "R6");
      if (obs_ss[1] && ss1 < 0) ss1 = stepn - 1 - t0;
    end
    chk_int("R6", "follower own soft-start", ss1, T);

    // R7 no chaining: ch0 -> ch1, ch1 -> ch2
    step('0, 1'b1, AW'(2), 4'b0100, "R7");
    step(4'b0001, 1'b0, '0, '0, "R7");
    chk("R7", "ch2 untouched", obs_pwm, 4'b1100);
    idle(T + 3, "R7");

    // R9 set wins over clear, then clear works, unmapped address ignored
    step('0, 1'b1, '0, '1, "R9");
    step(4'b0001, 1'b1, '0, 4'b0001, "R9");
    step('0, 1'b0, '0, '0, "R9");
    chk("R9", "set beats clear", obs_rd & 4'b0001, 4'b0001);
    step('0, 1'b1, '0, 4'b0001, "R9");
    step('0, 1'b0, '0, '0, "R9");
    chk("R9", "clear", obs_rd & 4'b0001, 4'b0000);
    step('0, 1'b1, AW'(N + 1), '1, "R9");
    step('0, 1'b0, AW'(N + 1), '0, "R9");
    chk("R9", "unmapped read", obs_rd, '0);
    idle(T + 3, "R9");

    // random mix checked against the model
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] o;
      for (int k = 0; k < N; k++) o[k] = ($urandom % 24) == 0;
      step(o, ($urandom % 8) == 0, AW'($urandom % (N + 2)), N'($urandom), "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule